// File: doc/BRIEF.md
# Watchdog Register Front End with Sequenced Unlock

This block is the register side of a two-stage watchdog. It decodes a simple synchronous register bus that carries a size code with every access: byte, halfword or word. The block holds the settings that the countdown core needs: the reboot policy, the clock scale, the first-stage interrupt kind, the enable and free-run modes, and two 20-bit preload values. It also produces single-cycle reload and flag-clear strobes for the core. The core returns a previous-reboot flag, and software reads that flag through the block.

Two address spaces are selected by `bus_cfg`. The configuration space holds the mode register and a write-once lock register. The protected space holds the two preloads and a reload/status register. A write to a protected register takes effect only after a two-write key sequence. Each completed key sequence grants exactly one protected halfword or word write.

The bus accepts one access per cycle. Read data is registered. Every write effect appears on the core outputs one cycle after the accepting clock edge.

Top module: `wdg_regif`

## Requirements
- R1: After reset the outputs are: reboot enabled, slow clock scale, interrupt type 0, unlocked, disabled, not free-running, both preloads 0xFFFFF, no strobes, and read data 0. The key sequence starts in its idle state.
- R2: The key sequence works in the protected space. A write of 0x80 to offset 0xC, at any size (code 0 byte, 1 halfword, 2 word), arms the sequence. If the next key-register write is 0x86, the sequence opens. Once the sequence is open, the next protected halfword or word write is granted.
- R3: A granted word write to offset 0x0 stores data bits 19:0 into preload 1. A granted word write to offset 0x4 stores data bits 19:0 into preload 2. The same writes without a grant leave both preloads unchanged.
- R4: A granted halfword write to offset 0xC with data bit 8 set pulses `core_reload` high for exactly one cycle, in the cycle after the write.
- R5: A granted halfword write to offset 0xC with data bit 9 or bit 12 set pulses `core_flag_clr` for one cycle, in the cycle after the write.
- R6: The first halfword or word protected write after the sequence opens uses up the grant, whatever its offset. A later write needs a new key sequence. Byte writes that are not key values leave the open grant in place.
- R7: A write of 0x86 to offset 0xC without an armed sequence does not open it.
- R8: A halfword read of protected offset 0xC returns 0x1200 when `core_prev_reboot` is high and 0 when it is low. Every other protected read, and every read of another size, returns 0. Read data appears in the cycle after the request.
- R9: A halfword write to configuration offset 0x0 sets the mode fields. Bit 5 set disables reboot. Bit 2 selects the fast scale. Bits 1:0 give the interrupt type. A halfword read of the same offset returns the fields at the same bit positions.
- R10: A byte write to configuration offset 0x4 sets lock from bit 0, enable from bit 1 and free-run from bit 2. A byte read returns them at the same positions. Once lock is 1, later lock-register writes are ignored until reset.
- R11: Configuration writes of the wrong size are ignored: the mode register accepts only halfword writes and the lock register accepts only byte writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_cfg | input | 1 | 1 = configuration space, 0 = protected space |
| bus_addr | input | ADDR_W | Byte offset |
| bus_size | input | 2 | Size code: 0 byte, 1 halfword, 2 word, 3 ignored |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| core_prev_reboot | input | 1 | Previous-reboot flag from the core |
| core_reboot_en | output | 1 | Reboot on second-stage expiry |
| core_fast_scale | output | 1 | Fast clock scale selected |
| core_irq_type | output | 2 | First-stage interrupt type |
| core_enable | output | 1 | Watchdog enabled |
| core_free_run | output | 1 | Restart after second stage |
| core_locked | output | 1 | Lock register frozen |
| core_t1_preload | output | PRE_W | Stage-one preload |
| core_t2_preload | output | PRE_W | Stage-two preload |
| core_reload | output | 1 | One-cycle reload strobe |
| core_flag_clr | output | 1 | One-cycle previous-reboot clear strobe |

## Verification
Every result is due exactly one clock edge after the access that causes it. This holds for register fields, preloads, strobes and read data alike, because each path from the bus to an output passes through one register. The bench drives each access on a falling edge and removes it on the next falling edge, then samples at that falling edge, which is half a cycle after the edge that captured the access. A strobe is checked high at that point and low one cycle later. This confirms it lasts a single cycle.

// File: rtl/wdg_regif_pkg.sv
package wdg_regif_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_NONE = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        KEY_IDLE  = 2'd0,
        KEY_ARMED = 2'd1,
        KEY_OPEN  = 2'd2
    } key_state_e;

    typedef struct packed {
        logic       reboot_en;
        logic       fast_scale;
        logic [1:0] irq_type;
        logic       locked;
        logic       enable;
        logic       free_run;
    } mode_t;

    localparam mode_t MODE_RESET = '{
        reboot_en:  1'b1,
        fast_scale: 1'b0,
        irq_type:   2'd0,
        locked:     1'b0,
        enable:     1'b0,
        free_run:   1'b0
    };

endpackage

// File: rtl/wdg_key_seq.sv
module wdg_key_seq
    import wdg_regif_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 32,
    parameter int KEY_OFS = 12,
    parameter int KEY_A   = 8'h80,
    parameter int KEY_B   = 8'h86
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_fire,
    input  logic [ADDR_W-1:0] addr,
    input  acc_size_e         size,
    input  logic [DATA_W-1:0] wdata,
    output logic              grant
);

    localparam logic [ADDR_W-1:0] KEY_ADDR = ADDR_W'(KEY_OFS);
    localparam logic [DATA_W-1:0] KEY_A_W  = DATA_W'(KEY_A);
    localparam logic [DATA_W-1:0] KEY_B_W  = DATA_W'(KEY_B);

    key_state_e        st_d, st_q;
    logic [DATA_W-1:0] masked;
    logic              at_key;

    always_comb begin
        unique case (size)
            SZ_BYTE: masked = {{(DATA_W-8){1'b0}}, wdata[7:0]};
            SZ_HALF: masked = {{(DATA_W-16){1'b0}}, wdata[15:0]};
            default: masked = wdata;
        endcase
        at_key = (addr == KEY_ADDR);
        st_d   = st_q;
        grant  = 1'b0;
        if (wr_fire && size != SZ_NONE) begin
            if (at_key && masked == KEY_A_W) begin
                st_d = KEY_ARMED;
            end else if (at_key && masked == KEY_B_W && st_q == KEY_ARMED) begin
                st_d = KEY_OPEN;
            end else if (st_q == KEY_OPEN && size != SZ_BYTE) begin
                grant = 1'b1;
                st_d  = KEY_IDLE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= KEY_IDLE;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/wdg_mode_regs.sv
module wdg_mode_regs
    import wdg_regif_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_wr,
    input  logic       lock_wr,
    input  logic [5:0] wbits,
    output mode_t      mode
);

    mode_t mode_d, mode_q;

    always_comb begin
        mode_d = mode_q;
        if (mode_wr) begin
            mode_d.reboot_en  = ~wbits[5];
            mode_d.fast_scale = wbits[2];
            mode_d.irq_type   = wbits[1:0];
        end
        if (lock_wr && !mode_q.locked) begin
            mode_d.locked   = wbits[0];
            mode_d.enable   = wbits[1];
            mode_d.free_run = wbits[2];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MODE_RESET;
        else        mode_q <= mode_d;
    end

    assign mode = mode_q;

endmodule

// File: rtl/wdg_regif.sv
module wdg_regif
    import wdg_regif_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int PRE_W  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic              bus_cfg,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              core_prev_reboot,
    output logic              core_reboot_en,
    output logic              core_fast_scale,
    output logic [1:0]        core_irq_type,
    output logic              core_enable,
    output logic              core_free_run,
    output logic              core_locked,
    output logic [PRE_W-1:0]  core_t1_preload,
    output logic [PRE_W-1:0]  core_t2_preload,
    output logic              core_reload,
    output logic              core_flag_clr
);

    localparam logic [ADDR_W-1:0] OFS_T1   = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFS_T2   = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] OFS_KEY  = ADDR_W'(12);
    localparam logic [ADDR_W-1:0] OFS_MODE = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFS_LOCK = ADDR_W'(4);
    localparam logic [DATA_W-1:0] FLAG_VAL = DATA_W'(16'h1200);

    typedef struct packed {
        logic [PRE_W-1:0]  t1;
        logic [PRE_W-1:0]  t2;
        logic              reload;
        logic              clr;
        logic [DATA_W-1:0] rdata;
    } regs_t;

    regs_t     r_d, r_q;
    acc_size_e size;
    logic      prot_wr, grant, mode_wr, lock_wr;
    mode_t     mode;

    assign size    = acc_size_e'(bus_size);
    assign prot_wr = bus_req && bus_we && !bus_cfg;
    assign mode_wr = bus_req && bus_we && bus_cfg && bus_addr == OFS_MODE && size == SZ_HALF;
    assign lock_wr = bus_req && bus_we && bus_cfg && bus_addr == OFS_LOCK && size == SZ_BYTE;

    wdg_key_seq #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .KEY_OFS(12)
    ) key_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_fire(prot_wr),
        .addr   (bus_addr),
        .size   (size),
        .wdata  (bus_wdata),
        .grant  (grant)
    );

    wdg_mode_regs mode_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode_wr(mode_wr),
        .lock_wr(lock_wr),
        .wbits  (bus_wdata[5:0]),
        .mode   (mode)
    );

    always_comb begin
        r_d        = r_q;
        r_d.reload = 1'b0;
        r_d.clr    = 1'b0;
        r_d.rdata  = '0;
        if (grant && size == SZ_WORD && bus_addr == OFS_T1) r_d.t1 = bus_wdata[PRE_W-1:0];
        if (grant && size == SZ_WORD && bus_addr == OFS_T2) r_d.t2 = bus_wdata[PRE_W-1:0];
        if (grant && size == SZ_HALF && bus_addr == OFS_KEY) begin
            r_d.reload = bus_wdata[8];
            r_d.clr    = bus_wdata[9] | bus_wdata[12];
        end
        if (bus_req && !bus_we) begin
            if (bus_cfg) begin
                if (bus_addr == OFS_MODE && size == SZ_HALF) begin
                    r_d.rdata[5]   = ~mode.reboot_en;
                    r_d.rdata[2]   = mode.fast_scale;
                    r_d.rdata[1:0] = mode.irq_type;
                end else if (bus_addr == OFS_LOCK && size == SZ_BYTE) begin
                    r_d.rdata[0] = mode.locked;
                    r_d.rdata[1] = mode.enable;
                    r_d.rdata[2] = mode.free_run;
                end
            end else if (bus_addr == OFS_KEY && size == SZ_HALF && core_prev_reboot) begin
                r_d.rdata = FLAG_VAL;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.t1     <= '1;
            r_q.t2     <= '1;
            r_q.reload <= 1'b0;
            r_q.clr    <= 1'b0;
            r_q.rdata  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign bus_rdata       = r_q.rdata;
    assign core_t1_preload = r_q.t1;
    assign core_t2_preload = r_q.t2;
    assign core_reload     = r_q.reload;
    assign core_flag_clr   = r_q.clr;
    assign core_reboot_en  = mode.reboot_en;
    assign core_fast_scale = mode.fast_scale;
    assign core_irq_type   = mode.irq_type;
    assign core_enable     = mode.enable;
    assign core_free_run   = mode.free_run;
    assign core_locked     = mode.locked;

endmodule

// File: rtl/wdg_regif_chk.sv
module wdg_regif_chk #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int PRE_W  = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_we,
    input logic              bus_cfg,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [1:0]        bus_size,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              core_enable,
    input logic              core_free_run,
    input logic              core_locked,
    input logic [PRE_W-1:0]  core_t1_preload,
    input logic              core_reload,
    input logic              core_flag_clr
);

    localparam logic [ADDR_W-1:0] KEY = ADDR_W'(12);
    localparam logic [ADDR_W-1:0] T1  = ADDR_W'(0);

    assert_lock_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
        core_locked |=> (core_locked && $stable(core_enable) && $stable(core_free_run)));

    assert_reload_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
        core_reload |-> $past(bus_req && bus_we && !bus_cfg && bus_size == 2'd1
                              && bus_addr == KEY && bus_wdata[8]));

    assert_clear_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        core_flag_clr |-> $past(bus_req && bus_we && !bus_cfg && bus_size == 2'd1
                                && bus_addr == KEY && (bus_wdata[9] || bus_wdata[12])));

    assert_preload_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(core_t1_preload) |-> $past(bus_req && bus_we && !bus_cfg
                                            && bus_size == 2'd2 && bus_addr == T1));

    assert_single_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
        core_reload |=> !core_reload);

    assert_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_req && !bus_we && !bus_cfg && bus_addr != KEY) |-> bus_rdata == '0);

endmodule

bind wdg_regif wdg_regif_chk #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .PRE_W (PRE_W)
) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .bus_req        (bus_req),
    .bus_we         (bus_we),
    .bus_cfg        (bus_cfg),
    .bus_addr       (bus_addr),
    .bus_size       (bus_size),
    .bus_wdata      (bus_wdata),
    .bus_rdata      (bus_rdata),
    .core_enable    (core_enable),
    .core_free_run  (core_free_run),
    .core_locked    (core_locked),
    .core_t1_preload(core_t1_preload),
    .core_reload    (core_reload),
    .core_flag_clr  (core_flag_clr)
);

// File: tb/wdg_regif_tb_top.sv
module wdg_regif_tb_top;

    localparam int ADDR_W = 4;
    localparam int DATA_W = 32;
    localparam int PRE_W  = 20;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_req = 1'b0, bus_we = 1'b0, bus_cfg = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [1:0]        bus_size = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              core_prev_reboot = 1'b0;
    logic              core_reboot_en, core_fast_scale, core_enable, core_free_run, core_locked;
    logic [1:0]        core_irq_type;
    logic [PRE_W-1:0]  core_t1_preload, core_t2_preload;
    logic              core_reload, core_flag_clr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    wdg_regif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRE_W(PRE_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we), .bus_cfg(bus_cfg),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .core_prev_reboot(core_prev_reboot), .core_reboot_en(core_reboot_en),
        .core_fast_scale(core_fast_scale), .core_irq_type(core_irq_type),
        .core_enable(core_enable), .core_free_run(core_free_run), .core_locked(core_locked),
        .core_t1_preload(core_t1_preload), .core_t2_preload(core_t2_preload),
        .core_reload(core_reload), .core_flag_clr(core_flag_clr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic cfg, input logic [3:0] a, input logic [1:0] sz, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_cfg = cfg; bus_addr = a; bus_size = sz; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic cfg, input logic [3:0] a, input logic [1:0] sz, output logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_cfg = cfg; bus_addr = a; bus_size = sz;
        @(negedge clk);
        d = bus_rdata;
        bus_req = 1'b0;
    endtask

    task automatic unlock(input logic [1:0] sz);
        wr(1'b0, 4'hC, sz, 32'h80);
        wr(1'b0, 4'hC, sz, 32'h86);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 reboot_en", core_reboot_en, 1);
        check("R1 fast", core_fast_scale, 0);
        check("R1 irq_type", core_irq_type, 0);
        check("R1 lock/en/free", {core_locked, core_enable, core_free_run}, 0);
        check("R1 t1", core_t1_preload, 20'hFFFFF);
        check("R1 t2", core_t2_preload, 20'hFFFFF);
        check("R1 strobes", {core_reload, core_flag_clr}, 0);
        rd(1'b1, 4'h0, 2'd1, d);
        check("R1 mode readback", d, 0);
    endtask

    task automatic t_preload();
        wr(1'b0, 4'h0, 2'd2, 32'h12345678);
        check("R3 no grant keeps t1", core_t1_preload, 20'hFFFFF);
        unlock(2'd0);
        wr(1'b0, 4'h0, 2'd2, 32'hABCDE123);
        check("R2 R3 byte key then t1", core_t1_preload, 20'hDE123);
        wr(1'b0, 4'h4, 2'd2, 32'h00011111);
        check("R6 grant used up, t2 kept", core_t2_preload, 20'hFFFFF);
        unlock(2'd1);
        wr(1'b0, 4'h4, 2'd2, 32'hFFF54321);
        check("R2 R3 half key then t2", core_t2_preload, 20'h54321);
    endtask

    task automatic t_reload();
        unlock(2'd2);
        wr(1'b0, 4'hC, 2'd1, 32'h0100);
        check("R4 reload pulse", core_reload, 1);
        check("R5 no clear on bit8", core_flag_clr, 0);
        @(negedge clk);
        check("R4 reload one cycle", core_reload, 0);
    endtask

    task automatic t_consume();
        unlock(2'd0);
        wr(1'b0, 4'h8, 2'd2, 32'h0);
        wr(1'b0, 4'hC, 2'd1, 32'h0100);
        check("R6 other offset used grant", core_reload, 0);
        unlock(2'd0);
        wr(1'b0, 4'h0, 2'd0, 32'h55);
        wr(1'b0, 4'h0, 2'd2, 32'h00011111);
        check("R6 byte keeps grant", core_t1_preload, 20'h11111);
    endtask

    task automatic t_bad_order();
        wr(1'b0, 4'hC, 2'd0, 32'h86);
        wr(1'b0, 4'h0, 2'd2, 32'h00022222);
        check("R7 lone 0x86 no unlock", core_t1_preload, 20'h11111);
    endtask

    task automatic t_flag();
        logic [31:0] d;
        core_prev_reboot = 1'b1;
        rd(1'b0, 4'hC, 2'd1, d);
        check("R8 flag half read", d, 32'h1200);
        rd(1'b0, 4'hC, 2'd2, d);
        check("R8 word read zero", d, 0);
        rd(1'b0, 4'h0, 2'd2, d);
        check("R8 preload read zero", d, 0);
        core_prev_reboot = 1'b0;
        rd(1'b0, 4'hC, 2'd1, d);
        check("R8 flag clear read", d, 0);
        unlock(2'd1);
        wr(1'b0, 4'hC, 2'd1, 32'h1000);
        check("R5 clear via bit12", {core_flag_clr, core_reload}, 2'b10);
        unlock(2'd1);
        wr(1'b0, 4'hC, 2'd1, 32'h0200);
        check("R5 clear via bit9", core_flag_clr, 1);
        @(negedge clk);
        check("R5 clear one cycle", core_flag_clr, 0);
    endtask

    task automatic t_mode();
        logic [31:0] d;
        wr(1'b1, 4'h0, 2'd1, 32'h0027);
        check("R9 fields", {core_reboot_en, core_fast_scale, core_irq_type}, 4'b0111);
        rd(1'b1, 4'h0, 2'd1, d);
        check("R9 readback", d, 32'h27);
        wr(1'b1, 4'h0, 2'd0, 32'h0);
        check("R11 byte to mode ignored", {core_reboot_en, core_fast_scale, core_irq_type}, 4'b0111);
        wr(1'b1, 4'h0, 2'd1, 32'h0001);
        check("R9 reboot back on", {core_reboot_en, core_fast_scale, core_irq_type}, 4'b1001);
    endtask

    task automatic t_lock();
        logic [31:0] d;
        wr(1'b1, 4'h4, 2'd0, 32'h6);
        check("R10 enable+free", {core_locked, core_enable, core_free_run}, 3'b011);
        rd(1'b1, 4'h4, 2'd0, d);
        check("R10 readback", d, 32'h6);
        wr(1'b1, 4'h4, 2'd2, 32'h0);
        check("R11 word to lock ignored", {core_locked, core_enable, core_free_run}, 3'b011);
        wr(1'b1, 4'h4, 2'd0, 32'h3);
        check("R10 locked", {core_locked, core_enable, core_free_run}, 3'b110);
        wr(1'b1, 4'h4, 2'd0, 32'h4);
        check("R10 frozen", {core_locked, core_enable, core_free_run}, 3'b110);
        rd(1'b1, 4'h4, 2'd0, d);
        check("R10 frozen readback", d, 32'h3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_preload();
        t_reload();
        t_consume();
        t_bad_order();
        t_flag();
        t_mode();
        t_lock();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule